// File: doc/BRIEF.md
# Snooping MESI Cache Cluster Controller

This block holds the coherence controllers for a small group of identical direct-mapped write-back caches that share one snooping bus. Each cache takes read and write requests from its own CPU port and keeps one MESI state per line. It drives bus transactions for a fill, a fill with ownership, an upgrade invalidate, a victim write-back and a non-allocating write. While another cache owns the bus it watches the transaction and updates its own copy. A snooping cache raises the shared signal when it sees a read of a line it holds. It flushes a dirty copy when another cache reads or claims that line.

A fixed-priority arbiter grants the bus to one requester per cycle, and each bus transaction completes in its granted cycle against an external single-port memory. Each line is one data word. The low `INDEX_W` address bits select the line and the upper bits form the tag. The `wr_alloc_i` input is sampled when a request is accepted and selects write-allocate (high) or write-around (low) for a write miss. A probe port returns the state and tag of one line index in every cache.

Top module: `snoop_mesi_cluster`

## Requirements
- R1: After reset every line in every cache reports state Invalid. State codes on the probe port are Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: A read miss that no other cache holds issues one bus read (command 1) and fills the line Exclusive with the memory word.
- R3: When a cache snoops a bus read of a line it holds in Exclusive or Shared, `bus_shared_o` is high in that bus cycle and both copies end Shared.
- R4: When a cache snoops a bus read (1) or read-for-ownership (2) of a line it holds Modified, its word is written to memory in that bus cycle and the requester receives that word. After a read both copies are Shared. After a read-for-ownership the holder is Invalid.
- R5: A write hit on a Shared line issues one invalidate (command 3). Every other copy becomes Invalid and the writer's line becomes Modified with the new data.
- R6: A write hit on an Exclusive or Modified line makes it Modified with no bus transaction.
- R7: A write miss with write-allocate on issues a read-for-ownership (command 2). Other copies become Invalid and the line becomes Modified holding the written word.
- R8: A write miss with write-allocate off issues a memory write (command 5) of the word. Other copies become Invalid and the writer's own line is left unchanged.
- R9: A fill whose target line holds a different tag in Modified first issues a write-back (command 4) of the victim's address and data. A clean victim is dropped with no extra bus transaction.
- R10: At most one bus transaction occurs per cycle. When several caches request together the lowest-numbered one is granted first, and the others stall and complete later.
- R11: Any read returns the most recent value written to that address by any cache or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_alloc_i | input | 1 | Write-miss policy: 1 allocate, 0 write-around |
| cpu_req_i | input | NC | Per-cache request strobe, accepted when that cache is idle |
| cpu_we_i | input | NC | Per-cache write enable |
| cpu_addr_i | input | NC*(INDEX_W+TAG_W) | Per-cache word address |
| cpu_wdata_i | input | NC*DATA_W | Per-cache write data |
| cpu_done_o | output | NC | One-cycle completion pulse |
| cpu_rdata_o | output | NC*DATA_W | Read data, valid with done |
| bus_valid_o | output | 1 | A bus transaction occurs this cycle |
| bus_cmd_o | output | 3 | Command: 1 read, 2 read-for-ownership, 3 invalidate, 4 write-back, 5 memory write |
| bus_src_o | output | SRC_W | Index of the granted cache |
| bus_addr_o | output | INDEX_W+TAG_W | Transaction address |
| bus_shared_o | output | 1 | Some snooper holds the line being read |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | INDEX_W+TAG_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, combinational from mem_addr_o |
| probe_idx_i | input | INDEX_W | Line index to observe |
| probe_state_o | output | 2*NC | State of the probed line, cache c at bits [2c+1:2c] |
| probe_tag_o | output | NC*TAG_W | Tag of the probed line per cache |

## Verification
The hardest case to reach is a race: a cache is waiting for the bus, or is about to change a line silently, while another cache's transaction changes that same line. For that case the bench issues write misses to one address from both caches in the same cycle. The lower-numbered cache wins. The stalled cache must then notice that its line changed, look it up again, and take the line from the winner by a flush. Every other combination of line states, tag conflicts and write policies is reached by a long pseudo-random stream of single operations on a two-cache, two-line, eight-address configuration. The bench checks each one against a reference model of the requirements: read data, every line state and tag, the full memory contents and the ordered list of bus transactions.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_INV  = 3'd3,
    CMD_WB   = 3'd4,
    CMD_WRT  = 3'd5
  } bus_cmd_e;
endpackage

// File: rtl/mesi_arb.sv
module mesi_arb #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = N'(1) << i;
    end
  end

  assert_gnt_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_gnt_needs_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  assert_gnt_lowest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> (((gnt_o - N'(1)) & req_i) == '0));
  assert_gnt_live_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/mesi_cache.sv
module mesi_cache
  import mesi_pkg::*;
#(
  parameter int INDEX_W = 1,
  parameter int TAG_W   = 2,
  parameter int DATA_W  = 8,
  localparam int ADDR_W = INDEX_W + TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_alloc_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output bus_cmd_e          bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              gnt_i,
  input  logic              bus_valid_i,
  input  bus_cmd_e          bus_cmd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_fill_i,
  input  logic              bus_shared_i,
  output logic              snp_hit_o,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_data_o,
  input  logic [INDEX_W-1:0] probe_idx_i,
  output mesi_e             probe_state_o,
  output logic [TAG_W-1:0]  probe_tag_o
);
  localparam int LINES = 1 << INDEX_W;

  typedef enum logic [1:0] {F_IDLE, F_LOOK, F_BUS} fsm_e;

  fsm_e              fsm_q;
  mesi_e             st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  logic              rq_we, rq_wa;
  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_wdata;
  bus_cmd_e          cmd_q;

  logic [INDEX_W-1:0] rq_idx, snp_idx;
  logic [TAG_W-1:0]   rq_tag, snp_tag;
  mesi_e              cur_st;
  logic               hit, snp_act, snp_hit, conflict;

  assign rq_idx  = rq_addr[INDEX_W-1:0];
  assign rq_tag  = rq_addr[ADDR_W-1:INDEX_W];
  assign snp_idx = bus_addr_i[INDEX_W-1:0];
  assign snp_tag = bus_addr_i[ADDR_W-1:INDEX_W];
  assign cur_st  = st_q[rq_idx];
  assign hit     = (cur_st != ST_I) && (tag_q[rq_idx] == rq_tag);

  // snoop only transactions owned by another cache
  assign snp_act  = bus_valid_i && !gnt_i;
  assign snp_hit  = snp_act && (st_q[snp_idx] != ST_I) && (tag_q[snp_idx] == snp_tag);
  // another cache touched our pending index: re-evaluate
  assign conflict = snp_act && (snp_idx == rq_idx);

  assign snp_hit_o   = snp_hit && (bus_cmd_i == CMD_RD);
  assign snp_flush_o = snp_hit && (st_q[snp_idx] == ST_M) &&
                       ((bus_cmd_i == CMD_RD) || (bus_cmd_i == CMD_RDX));
  assign snp_data_o  = dat_q[snp_idx];

  assign bus_req_o   = (fsm_q == F_BUS);
  assign bus_cmd_o   = (fsm_q == F_BUS) ? cmd_q : CMD_NONE;
  assign bus_addr_o  = (cmd_q == CMD_WB) ? {tag_q[rq_idx], rq_idx} : rq_addr;
  assign bus_wdata_o = (cmd_q == CMD_WB) ? dat_q[rq_idx] : rq_wdata;

  assign probe_state_o = st_q[probe_idx_i];
  assign probe_tag_o   = tag_q[probe_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q       <= F_IDLE;
      cmd_q       <= CMD_NONE;
      rq_we       <= 1'b0;
      rq_wa       <= 1'b0;
      rq_addr     <= '0;
      rq_wdata    <= '0;
      cpu_done_o  <= 1'b0;
      cpu_rdata_o <= '0;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      cpu_done_o <= 1'b0;
      if (snp_hit) begin
        unique case (bus_cmd_i)
          CMD_RD:                    st_q[snp_idx] <= ST_S;
          CMD_RDX, CMD_INV, CMD_WRT: st_q[snp_idx] <= ST_I;
          default: ;
        endcase
      end
      unique case (fsm_q)
        F_IDLE: begin
          if (cpu_req_i) begin
            rq_we    <= cpu_we_i;
            rq_wa    <= wr_alloc_i;
            rq_addr  <= cpu_addr_i;
            rq_wdata <= cpu_wdata_i;
            fsm_q    <= F_LOOK;
          end
        end
        F_LOOK: begin
          if (!conflict) begin
            if (hit) begin
              if (!rq_we) begin
                cpu_rdata_o <= dat_q[rq_idx];
                cpu_done_o  <= 1'b1;
                fsm_q       <= F_IDLE;
              end else if (cur_st != ST_S) begin
                dat_q[rq_idx] <= rq_wdata;
                st_q[rq_idx]  <= ST_M;
                cpu_done_o    <= 1'b1;
                fsm_q         <= F_IDLE;
              end else begin
                cmd_q <= CMD_INV;
                fsm_q <= F_BUS;
              end
            end else if (rq_we && !rq_wa) begin
              cmd_q <= CMD_WRT;
              fsm_q <= F_BUS;
            end else if (cur_st == ST_M) begin
              cmd_q <= CMD_WB;
              fsm_q <= F_BUS;
            end else begin
              cmd_q <= rq_we ? CMD_RDX : CMD_RD;
              fsm_q <= F_BUS;
            end
          end
        end
        F_BUS: begin
          if (gnt_i) begin
            unique case (cmd_q)
              CMD_WB: begin
                st_q[rq_idx] <= ST_I;
                fsm_q        <= F_LOOK;
              end
              CMD_RD: begin
                tag_q[rq_idx] <= rq_tag;
                dat_q[rq_idx] <= bus_fill_i;
                st_q[rq_idx]  <= bus_shared_i ? ST_S : ST_E;
                cpu_rdata_o   <= bus_fill_i;
                cpu_done_o    <= 1'b1;
                fsm_q         <= F_IDLE;
              end
              CMD_RDX: begin
                tag_q[rq_idx] <= rq_tag;
                dat_q[rq_idx] <= rq_wdata;
                st_q[rq_idx]  <= ST_M;
                cpu_done_o    <= 1'b1;
                fsm_q         <= F_IDLE;
              end
              CMD_INV: begin
                dat_q[rq_idx] <= rq_wdata;
                st_q[rq_idx]  <= ST_M;
                cpu_done_o    <= 1'b1;
                fsm_q         <= F_IDLE;
              end
              default: begin
                cpu_done_o <= 1'b1;
                fsm_q      <= F_IDLE;
              end
            endcase
          end else if (conflict) begin
            fsm_q <= F_LOOK;
          end
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  assert_fill_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i && bus_cmd_o == CMD_RD) |=>
      (st_q[rq_idx] == ($past(bus_shared_i) ? ST_S : ST_E)));
  assert_silent_upgrade_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == F_LOOK && !conflict && hit && rq_we && cur_st == ST_E) |=>
      (st_q[rq_idx] == ST_M && !bus_req_o && cpu_done_o));
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !gnt_i && !conflict) |=>
      (bus_req_o && $stable(bus_addr_o) && $stable(bus_cmd_o)));
  assert_snoop_read_shared_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hit_o |=> (st_q[$past(snp_idx)] == ST_S));
  assert_ownership_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i && (bus_cmd_o == CMD_RDX || bus_cmd_o == CMD_INV)) |=>
      (st_q[rq_idx] == ST_M && dat_q[rq_idx] == rq_wdata));
endmodule

// File: rtl/snoop_mesi_cluster.sv
module snoop_mesi_cluster
  import mesi_pkg::*;
#(
  parameter int NC      = 2,
  parameter int INDEX_W = 1,
  parameter int TAG_W   = 2,
  parameter int DATA_W  = 8,
  localparam int ADDR_W = INDEX_W + TAG_W,
  localparam int SRC_W  = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_alloc_i,
  input  logic [NC-1:0]        cpu_req_i,
  input  logic [NC-1:0]        cpu_we_i,
  input  logic [NC*ADDR_W-1:0] cpu_addr_i,
  input  logic [NC*DATA_W-1:0] cpu_wdata_i,
  output logic [NC-1:0]        cpu_done_o,
  output logic [NC*DATA_W-1:0] cpu_rdata_o,
  output logic                 bus_valid_o,
  output logic [2:0]           bus_cmd_o,
  output logic [SRC_W-1:0]     bus_src_o,
  output logic [ADDR_W-1:0]    bus_addr_o,
  output logic                 bus_shared_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  input  logic [DATA_W-1:0]    mem_rdata_i,
  input  logic [INDEX_W-1:0]   probe_idx_i,
  output logic [2*NC-1:0]      probe_state_o,
  output logic [NC*TAG_W-1:0]  probe_tag_o
);
  logic [NC-1:0]     req, gnt, shr, flu;
  bus_cmd_e          c_cmd  [NC];
  logic [ADDR_W-1:0] c_addr [NC];
  logic [DATA_W-1:0] c_wd   [NC];
  logic [DATA_W-1:0] c_sd   [NC];
  mesi_e             c_pst  [NC];

  bus_cmd_e          b_cmd;
  logic [ADDR_W-1:0] b_addr;
  logic [DATA_W-1:0] b_wd, f_dat, fill;
  logic              any_flush;

  mesi_arb #(.N(NC)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req),
    .gnt_o (gnt)
  );

  always_comb begin
    b_cmd     = CMD_NONE;
    b_addr    = '0;
    b_wd      = '0;
    bus_src_o = '0;
    f_dat     = '0;
    for (int i = 0; i < NC; i++) begin
      if (gnt[i]) begin
        b_cmd     = c_cmd[i];
        b_addr    = c_addr[i];
        b_wd      = c_wd[i];
        bus_src_o = SRC_W'(i);
      end
      if (flu[i]) f_dat = c_sd[i];
    end
  end

  assign bus_valid_o  = |gnt;
  assign bus_cmd_o    = b_cmd;
  assign bus_addr_o   = b_addr;
  assign bus_shared_o = |shr;
  assign any_flush    = |flu;
  assign fill         = any_flush ? f_dat : mem_rdata_i;
  assign mem_addr_o   = b_addr;
  assign mem_we_o     = bus_valid_o && ((b_cmd == CMD_WB) || (b_cmd == CMD_WRT) || any_flush);
  assign mem_wdata_o  = any_flush ? f_dat : b_wd;

  for (genvar g = 0; g < NC; g++) begin : g_cache
    mesi_cache #(
      .INDEX_W(INDEX_W),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
    ) u_cache (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_alloc_i   (wr_alloc_i),
      .cpu_req_i    (cpu_req_i[g]),
      .cpu_we_i     (cpu_we_i[g]),
      .cpu_addr_i   (cpu_addr_i[g*ADDR_W +: ADDR_W]),
      .cpu_wdata_i  (cpu_wdata_i[g*DATA_W +: DATA_W]),
      .cpu_done_o   (cpu_done_o[g]),
      .cpu_rdata_o  (cpu_rdata_o[g*DATA_W +: DATA_W]),
      .bus_req_o    (req[g]),
      .bus_cmd_o    (c_cmd[g]),
      .bus_addr_o   (c_addr[g]),
      .bus_wdata_o  (c_wd[g]),
      .gnt_i        (gnt[g]),
      .bus_valid_i  (bus_valid_o),
      .bus_cmd_i    (b_cmd),
      .bus_addr_i   (b_addr),
      .bus_fill_i   (fill),
      .bus_shared_i (bus_shared_o),
      .snp_hit_o    (shr[g]),
      .snp_flush_o  (flu[g]),
      .snp_data_o   (c_sd[g]),
      .probe_idx_i  (probe_idx_i),
      .probe_state_o(c_pst[g]),
      .probe_tag_o  (probe_tag_o[g*TAG_W +: TAG_W])
    );
    assign probe_state_o[2*g +: 2] = c_pst[g];
  end

  assert_single_owner_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flu));
  assert_flush_is_shared_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_flush && b_cmd == CMD_RD) |-> bus_shared_o);
  assert_no_snoop_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_o |-> (shr == '0 && flu == '0));
endmodule

// File: tb/snoop_mesi_cluster_tb.sv
module snoop_mesi_cluster_tb;
  localparam int NC = 2, IW = 1, TW = 2, DW = 8, AW = IW + TW, NA = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, wa = 1'b0;
  logic [NC-1:0] req = '0, we = '0, done;
  logic [NC*AW-1:0] addr = '0;
  logic [NC*DW-1:0] wdat = '0, rdat;
  logic bvalid, bshared, mem_we;
  logic [2:0] bcmd;
  logic [0:0] bsrc;
  logic [AW-1:0] baddr, mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [IW-1:0] pidx = '0;
  logic [2*NC-1:0] pst;
  logic [NC*TW-1:0] ptag;

  always #5 clk = ~clk;

  snoop_mesi_cluster u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_alloc_i(wa),
    .cpu_req_i(req), .cpu_we_i(we), .cpu_addr_i(addr), .cpu_wdata_i(wdat),
    .cpu_done_o(done), .cpu_rdata_o(rdat),
    .bus_valid_o(bvalid), .bus_cmd_o(bcmd), .bus_src_o(bsrc), .bus_addr_o(baddr),
    .bus_shared_o(bshared), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .probe_idx_i(pidx), .probe_state_o(pst), .probe_tag_o(ptag)
  );

  logic [DW-1:0] mem [NA];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  int checks = 0, fails = 0;

  // bus log, sampled mid-cycle
  int nlog = 0;
  int lg_cmd [8], lg_addr [8], lg_sh [8], lg_src [8];
  always @(negedge clk) if (bvalid) begin
    if (nlog < 8) begin
      lg_cmd[nlog] = bcmd; lg_addr[nlog] = baddr; lg_sh[nlog] = bshared; lg_src[nlog] = bsrc;
    end
    nlog++;
  end

  // reference model
  int m_st [NC][2];
  int m_tag [NC][2];
  logic [DW-1:0] m_dat [NC][2];
  logic [DW-1:0] x_mem [NA];
  int ne;
  int e_cmd [4], e_addr [4], e_sh [4];

  task automatic chk(input bit ok, input string lab, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", lab, what, act, exp);
    end
  endtask

  task automatic push(input int c, input int a, input int s);
    e_cmd[ne] = c; e_addr[ne] = a; e_sh[ne] = s; ne++;
  endtask

  task automatic model(input int c, input bit w, input int a, input logic [DW-1:0] wd,
                       input bit al, output logic [DW-1:0] rd, output string lab);
    int idx = a % 2, tg = a / 2, o = 1 - c;
    bit hit = (m_st[c][idx] != 0) && (m_tag[c][idx] == tg);
    bit oh  = (m_st[o][idx] != 0) && (m_tag[o][idx] == tg);
    bit om  = oh && (m_st[o][idx] == 3);
    bit vic = 0;
    ne = 0; rd = '0;
    if (hit) begin
      if (!w) begin rd = m_dat[c][idx]; lab = "R11"; end
      else if (m_st[c][idx] == 1) begin
        push(3, a, 0); if (oh) m_st[o][idx] = 0;
        m_st[c][idx] = 3; m_dat[c][idx] = wd; lab = "R5";
      end else begin m_st[c][idx] = 3; m_dat[c][idx] = wd; lab = "R6"; end
    end else if (w && !al) begin
      push(5, a, 0); if (oh) m_st[o][idx] = 0; x_mem[a] = wd; lab = "R8";
    end else begin
      if (m_st[c][idx] == 3) begin
        push(4, m_tag[c][idx] * 2 + idx, 0);
        x_mem[m_tag[c][idx] * 2 + idx] = m_dat[c][idx];
        m_st[c][idx] = 0; vic = 1;
      end
      if (om) x_mem[a] = m_dat[o][idx];
      if (!w) begin
        push(1, a, oh);
        if (oh) m_st[o][idx] = 1;
        m_st[c][idx] = oh ? 1 : 2; m_tag[c][idx] = tg; m_dat[c][idx] = x_mem[a];
        rd = x_mem[a];
        lab = vic ? "R9" : om ? "R4" : oh ? "R3" : "R2";
      end else begin
        push(2, a, 0);
        if (oh) m_st[o][idx] = 0;
        m_st[c][idx] = 3; m_tag[c][idx] = tg; m_dat[c][idx] = wd;
        lab = vic ? "R9" : om ? "R4" : "R7";
      end
    end
  endtask

  task automatic check_all(input string lab);
    for (int i = 0; i < 2; i++) begin
      pidx = IW'(i);
      #1;
      for (int c = 0; c < NC; c++) begin
        chk(pst[2*c +: 2] == 2'(m_st[c][i]), lab, $sformatf("state c%0d idx%0d", c, i),
            pst[2*c +: 2], m_st[c][i]);
        if (m_st[c][i] != 0)
          chk(ptag[TW*c +: TW] == TW'(m_tag[c][i]), lab, $sformatf("tag c%0d idx%0d", c, i),
              ptag[TW*c +: TW], m_tag[c][i]);
      end
    end
    for (int a = 0; a < NA; a++)
      chk(mem[a] == x_mem[a], lab, $sformatf("mem[%0d]", a), mem[a], x_mem[a]);
  endtask

  task automatic do_op(input int c, input bit w, input int a, input logic [DW-1:0] wd, input bit al);
    logic [DW-1:0] xr;
    string lab;
    int t = 0;
    model(c, w, a, wd, al, xr, lab);
    @(negedge clk);
    nlog = 0;
    req[c] = 1'b1; we[c] = w; addr[c*AW +: AW] = AW'(a); wdat[c*DW +: DW] = wd; wa = al;
    @(negedge clk);
    req[c] = 1'b0;
    while (!done[c] && t < 100) begin @(negedge clk); t++; end
    chk(done[c], lab, "completion", done[c], 1);
    if (!w) chk(rdat[c*DW +: DW] == xr, lab, "read data", rdat[c*DW +: DW], xr);
    chk(nlog == ne, lab, "bus transaction count", nlog, ne);
    for (int k = 0; k < ne && k < nlog; k++) begin
      chk(lg_cmd[k] == e_cmd[k], lab, $sformatf("bus cmd #%0d", k), lg_cmd[k], e_cmd[k]);
      chk(lg_addr[k] == e_addr[k], lab, $sformatf("bus addr #%0d", k), lg_addr[k], e_addr[k]);
      chk(lg_sh[k] == e_sh[k], lab, $sformatf("shared #%0d", k), lg_sh[k], e_sh[k]);
      chk(lg_src[k] == c, lab, $sformatf("bus src #%0d", k), lg_src[k], c);
    end
    check_all(lab);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    int d0, d1;
    for (int a = 0; a < NA; a++) begin mem[a] = DW'(8'h10 + a); x_mem[a] = DW'(8'h10 + a); end
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < 2; i++) begin m_st[c][i] = 0; m_tag[c][i] = 0; m_dat[c][i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R10: simultaneous write misses to one address, cache 0 wins
    nlog = 0; d0 = -1; d1 = -1;
    req = 2'b11; we = 2'b11; wa = 1'b1;
    addr = {AW'(6), AW'(6)}; wdat = {8'hB0, 8'hA0};
    @(negedge clk);
    req = '0;
    for (int t = 1; t < 60 && (d0 < 0 || d1 < 0); t++) begin
      if (done[0] && d0 < 0) d0 = t;
      if (done[1] && d1 < 0) d1 = t;
      @(negedge clk);
    end
    chk(d0 > 0 && d1 > d0, "R10", "cache1 completes after cache0", d1, d0 + 1);
    chk(nlog == 2, "R10", "transaction count", nlog, 2);
    chk(lg_src[0] == 0 && lg_cmd[0] == 2, "R10", "first grant src/cmd", lg_src[0] * 16 + lg_cmd[0], 2);
    chk(lg_src[1] == 1 && lg_cmd[1] == 2, "R10", "second grant src/cmd", lg_src[1] * 16 + lg_cmd[1], 18);
    m_st[1][0] = 3; m_tag[1][0] = 3; m_dat[1][0] = 8'hB0; x_mem[6] = 8'hA0;
    check_all("R4");

    // directed walk through each transition
    do_op(0, 0, 2, 0, 1);        // R2 exclusive fill
    do_op(1, 0, 2, 0, 1);        // R9 victim M at idx0, then R3 shared
    do_op(1, 0, 2, 0, 1);        // R11 read hit
    do_op(0, 1, 2, 8'h55, 1);    // R5 invalidate
    do_op(1, 0, 2, 0, 1);        // R4 flush on read
    do_op(0, 0, 3, 0, 1);        // R2
    do_op(0, 1, 3, 8'h66, 1);    // R6 silent E->M
    do_op(0, 1, 3, 8'h67, 1);    // R6 M->M
    do_op(0, 0, 5, 0, 1);        // R9 dirty victim write-back
    do_op(0, 0, 7, 0, 1);        // R9 clean victim dropped
    do_op(1, 1, 7, 8'h77, 0);    // R8 write-around, invalidates cache 0
    do_op(1, 1, 1, 8'h11, 1);    // R7 allocate
    do_op(0, 1, 1, 8'h12, 1);    // R4 flush on read-for-ownership

    // pseudo-random sweep
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_op(int'(lf[0]), lf[1] & lf[2], int'(lf[5:3]), lf[15:8], lf[6] | lf[7]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule